// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block sits in the address stage of a load/store unit. For each request it takes an addressing-mode code, an operand-size code, the base register value, the index register value and a 4-bit displacement field. It returns the memory effective address and, for the two auto-modify modes, the new base value together with a strobe that tells the register file to write it back. The register file and the memory access itself live elsewhere.

The operand size sets a step of 1, 2 or 4 bytes. Post-increment addresses memory with the unmodified base and then writes back base plus step. Pre-decrement subtracts the step first and uses that reduced value both as the address and as the write-back value. The displacement mode zero-extends the 4-bit field and scales it by the step. The indexed mode adds the index register to the base without scaling. Register-direct requests return a response but no address. All arithmetic wraps modulo 2^32 without any indication. Every result is registered, so a request accepted on one clock edge shows its outputs after that edge until the next one.

Top module: `lsu_ea_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rsp_valid`, `addr_valid`, `wb_en`, `bad_req`, `eff_addr` and `wb_value` all become 0.
- R2: Every output reflects the request sampled at the previous rising edge. A cycle with `req_valid` low produces `rsp_valid`, `addr_valid`, `wb_en` and `bad_req` all 0 on the next cycle. A cycle with `req_valid` high produces `rsp_valid` 1.
- R3: Mode 0 (register direct) with a legal size gives `rsp_valid` 1, `addr_valid` 0 and `wb_en` 0.
- R4: Mode 1 (indirect) gives `addr_valid` 1 with `eff_addr` equal to `base_val` and `wb_en` 0.
- R5: Mode 2 (post-increment) gives `eff_addr` equal to `base_val` and `wb_en` 1 with `wb_value` equal to `base_val` plus the step. The step is 1 for size code 0 (byte), 2 for size code 1 (word) and 4 for size code 2 (longword).
- R6: Mode 3 (pre-decrement) gives `eff_addr` equal to `base_val` minus the step, `wb_en` 1, and `wb_value` equal to `eff_addr`.
- R7: Mode 4 (displacement) gives `eff_addr` equal to `base_val` plus the zero-extended `disp` times the step, and `wb_en` 0. The largest offsets are 15, 30 and 60.
- R8: Mode 5 (indexed) gives `eff_addr` equal to `base_val` plus `index_val`, with no scaling, and `wb_en` 0.
- R9: Mode codes 6 and 7, and size code 3 in any mode, give `bad_req` 1 with `addr_valid` 0 and `wb_en` 0.
- R10: All address and write-back arithmetic is modulo 2^32. For example, base 0xFFFFFFFF post-incremented as a byte writes back 0, and base 0 pre-decremented as a longword addresses 0xFFFFFFFC.
- R11: `eff_addr` reads 0 whenever `addr_valid` is 0, and `wb_value` reads 0 whenever `wb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| mode | input | 3 | Addressing-mode code (0 to 5 legal) |
| size | input | 2 | Operand-size code: 0 byte, 1 word, 2 longword |
| base_val | input | 32 | Current base register value |
| index_val | input | 32 | Index register value used by mode 5 |
| disp | input | 4 | Unsigned displacement field used by mode 4 |
| rsp_valid | output | 1 | A response for last cycle's request is present |
| addr_valid | output | 1 | `eff_addr` carries a memory address |
| eff_addr | output | 32 | Effective address |
| wb_en | output | 1 | Write `wb_value` back to the base register |
| wb_value | output | 32 | Updated base register value |
| bad_req | output | 1 | The request had an unused mode or size code |

## Verification
The clocked assertions take for granted that the mode, size and base inputs are driven to known values in every cycle after reset and that they are held steady around each rising edge. The checks that look back one cycle compare the outputs with the inputs sampled at that edge. The bench meets these assumptions by changing inputs only on falling edges and by driving zeros on idle cycles. The stimulus covers every mode and size code, including the unused ones, at base values 0 and 0xFFFFFFFF and around them, at displacements 0 and 15, and at index values that wrap.

// File: rtl/ea_gen_pkg.sv
// Package: ea_gen_pkg
// Shared encodings for the load/store effective address generator.
// Assumes the mode input is 3 bits and the size input is 2 bits wide.
package ea_gen_pkg;

    // Mode codes seen on the mode input; 6 and 7 are unused.
    localparam logic [2:0] MODE_DIRECT  = 3'd0;
    localparam logic [2:0] MODE_IND     = 3'd1;
    localparam logic [2:0] MODE_POSTINC = 3'd2;
    localparam logic [2:0] MODE_PREDEC  = 3'd3;
    localparam logic [2:0] MODE_DISP    = 3'd4;
    localparam logic [2:0] MODE_INDEX   = 3'd5;

    // Size codes; code 3 is unused.
    localparam logic [1:0] SIZE_BYTE = 2'd0;
    localparam logic [1:0] SIZE_WORD = 2'd1;
    localparam logic [1:0] SIZE_LONG = 2'd2;

    // Source selected for the effective address.
    typedef enum logic [2:0] {
        EA_NONE,
        EA_BASE,
        EA_BASE_DEC,
        EA_BASE_DISP,
        EA_BASE_IDX
    } ea_sel_e;

    // Source selected for the write-back value.
    typedef enum logic [1:0] {
        WB_NONE,
        WB_INC,
        WB_DEC
    } wb_sel_e;

endpackage

// File: rtl/ea_mode_decode.sv
// Module: ea_mode_decode
// Turns the mode and size codes into datapath selects, the step shift
// (log2 of the operand size) and a legality flag.
// Assumes nothing about the request strobe; it decodes every cycle.
module ea_mode_decode
    import ea_gen_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] size,
    output logic       legal,
    output logic       addr_req,
    output logic       wb_req,
    output ea_sel_e    ea_sel,
    output wb_sel_e    wb_sel,
    output logic [1:0] step_shift
);

    logic mode_ok;
    logic size_ok;

    // Size code to shift amount: byte 0, word 1, longword 2.
    always_comb begin
        size_ok    = 1'b1;
        step_shift = 2'd0;
        case (size)
            SIZE_BYTE: step_shift = 2'd0;
            SIZE_WORD: step_shift = 2'd1;
            SIZE_LONG: step_shift = 2'd2;
            default: begin
                step_shift = 2'd0;
                size_ok    = 1'b0;
            end
        endcase
    end

    // Mode code to address and write-back selects.
    always_comb begin
        mode_ok   = 1'b1;
        ea_sel    = EA_NONE;
        wb_sel    = WB_NONE;
        case (mode)
            MODE_DIRECT:  ea_sel = EA_NONE;
            MODE_IND:     ea_sel = EA_BASE;
            MODE_POSTINC: begin
                ea_sel = EA_BASE;
                wb_sel = WB_INC;
            end
            MODE_PREDEC: begin
                ea_sel = EA_BASE_DEC;
                wb_sel = WB_DEC;
            end
            MODE_DISP:    ea_sel = EA_BASE_DISP;
            MODE_INDEX:   ea_sel = EA_BASE_IDX;
            default:      mode_ok = 1'b0;
        endcase
    end

    // Combine legality and qualify the address and write-back requests.
    always_comb begin
        legal    = mode_ok && size_ok;
        addr_req = legal && (ea_sel != EA_NONE);
        wb_req   = legal && (wb_sel != WB_NONE);
    end

endmodule

// File: rtl/ea_addr_path.sv
// Module: ea_addr_path
// Arithmetic for the effective address and the new base value.
// All sums wrap modulo 2**AW. Assumes DW + 2 <= AW so a scaled
// displacement always fits.
module ea_addr_path
    import ea_gen_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 4
) (
    input  ea_sel_e       ea_sel,
    input  wb_sel_e       wb_sel,
    input  logic [1:0]    step_shift,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] ea_next,
    output logic [AW-1:0] wbv_next
);

    localparam int SCALED_W = DW + 3;

    logic [AW-1:0]       step;
    logic [SCALED_W-1:0] disp_scaled;
    logic [AW-1:0]       base_inc;
    logic [AW-1:0]       base_dec;
    logic [AW-1:0]       base_disp;
    logic [AW-1:0]       base_idx;

    // Step and scaled displacement from the size shift.
    always_comb begin
        step        = AW'(1) << step_shift;
        disp_scaled = SCALED_W'(disp) << step_shift;
    end

    // The four adders, each wrapping at the address width.
    always_comb begin
        base_inc  = base_val + step;
        base_dec  = base_val - step;
        base_disp = base_val + AW'(disp_scaled);
        base_idx  = base_val + index_val;
    end

    // Effective address select.
    always_comb begin
        case (ea_sel)
            EA_BASE:      ea_next = base_val;
            EA_BASE_DEC:  ea_next = base_dec;
            EA_BASE_DISP: ea_next = base_disp;
            EA_BASE_IDX:  ea_next = base_idx;
            default:      ea_next = '0;
        endcase
    end

    // Write-back value select.
    always_comb begin
        case (wb_sel)
            WB_INC:  wbv_next = base_inc;
            WB_DEC:  wbv_next = base_dec;
            default: wbv_next = '0;
        endcase
    end

endmodule

// File: rtl/ea_out_reg.sv
// Module: ea_out_reg
// Output register stage: one cycle from request to response.
// Addresses and write-back values are zeroed when not qualified.
// Assumes a synchronous active-low reset.
module ea_out_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          legal,
    input  logic          addr_req,
    input  logic          wb_req,
    input  logic [AW-1:0] ea_next,
    input  logic [AW-1:0] wbv_next,
    output logic          rsp_valid,
    output logic          addr_valid,
    output logic [AW-1:0] eff_addr,
    output logic          wb_en,
    output logic [AW-1:0] wb_value,
    output logic          bad_req
);

    logic take_addr;
    logic take_wb;

    // Qualify each result with the request strobe.
    always_comb begin
        take_addr = req_valid && addr_req;
        take_wb   = req_valid && wb_req;
    end

    // Register the response; reset clears every flag and value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            addr_valid <= 1'b0;
            eff_addr   <= '0;
            wb_en      <= 1'b0;
            wb_value   <= '0;
            bad_req    <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            addr_valid <= take_addr;
            eff_addr   <= take_addr ? ea_next : '0;
            wb_en      <= take_wb;
            wb_value   <= take_wb ? wbv_next : '0;
            bad_req    <= req_valid && !legal;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !addr_valid && !wb_en && !bad_req); // R2
    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |-> !addr_valid && !wb_en); // R9
    AST_WB_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> addr_valid && rsp_valid); // R5
    AST_ZERO_ADDR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> eff_addr == '0); // R11
    AST_ZERO_WB_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |-> wb_value == '0); // R11

endmodule

// File: rtl/lsu_ea_gen.sv
// Module: lsu_ea_gen
// Top of the load/store effective address generator: decode, address
// arithmetic and a registered output stage.
// Assumes the register file applies wb_value when wb_en is high.
module lsu_ea_gen
    import ea_gen_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    mode,
    input  logic [1:0]    size,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [DW-1:0] disp,
    output logic          rsp_valid,
    output logic          addr_valid,
    output logic [AW-1:0] eff_addr,
    output logic          wb_en,
    output logic [AW-1:0] wb_value,
    output logic          bad_req
);

    logic          legal;
    logic          addr_req;
    logic          wb_req;
    ea_sel_e       ea_sel;
    wb_sel_e       wb_sel;
    logic [1:0]    step_shift;
    logic [AW-1:0] ea_next;
    logic [AW-1:0] wbv_next;

    ea_mode_decode u_decode (
        .mode       (mode),
        .size       (size),
        .legal      (legal),
        .addr_req   (addr_req),
        .wb_req     (wb_req),
        .ea_sel     (ea_sel),
        .wb_sel     (wb_sel),
        .step_shift (step_shift)
    );

    ea_addr_path #(.AW(AW), .DW(DW)) u_path (
        .ea_sel     (ea_sel),
        .wb_sel     (wb_sel),
        .step_shift (step_shift),
        .base_val   (base_val),
        .index_val  (index_val),
        .disp       (disp),
        .ea_next    (ea_next),
        .wbv_next   (wbv_next)
    );

    ea_out_reg #(.AW(AW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .legal      (legal),
        .addr_req   (addr_req),
        .wb_req     (wb_req),
        .ea_next    (ea_next),
        .wbv_next   (wbv_next),
        .rsp_valid  (rsp_valid),
        .addr_valid (addr_valid),
        .eff_addr   (eff_addr),
        .wb_en      (wb_en),
        .wb_value   (wb_value),
        .bad_req    (bad_req)
    );

    AST_DIRECT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode == MODE_DIRECT |=> !addr_valid && !wb_en); // R3
    AST_POSTINC_USES_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode == MODE_POSTINC && size != 2'd3
        |=> wb_en && eff_addr == $past(base_val)); // R5
    AST_PREDEC_EA_IS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode == MODE_PREDEC && size != 2'd3
        |=> wb_en && eff_addr == wb_value); // R6
    AST_BAD_MODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mode > MODE_INDEX |=> bad_req); // R9

endmodule

// File: tb/tb_lsu_ea_gen.sv
// Scoreboard bench for lsu_ea_gen: a driver task applies a request on a
// falling edge and queues the expected response; a monitor pops and
// compares one item just after every rising edge.
module tb_lsu_ea_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  size;
        logic        rv;
        logic        av;
        logic [31:0] ea;
        logic        we;
        logic [31:0] wv;
        logic        bad;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [3:0]  disp = '0;
    logic        rsp_valid;
    logic        addr_valid;
    logic [31:0] eff_addr;
    logic        wb_en;
    logic [31:0] wb_value;
    logic        bad_req;

    int   checks = 0;
    int   failures = 0;
    bit   monitor_on = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lsu_ea_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .mode       (mode),
        .size       (size),
        .base_val   (base_val),
        .index_val  (index_val),
        .disp       (disp),
        .rsp_valid  (rsp_valid),
        .addr_valid (addr_valid),
        .eff_addr   (eff_addr),
        .wb_en      (wb_en),
        .wb_value   (wb_value),
        .bad_req    (bad_req)
    );

    // Requirement tag for a request's mode and size.
    function automatic string req_tag(input exp_t e);
        if (!e.rv) return "R2";
        if (e.mode > 3'd5 || e.size == 2'd3) return "R9";
        case (e.mode)
            3'd0:    return "R3";
            3'd1:    return "R4";
            3'd2:    return "R5/R10";
            3'd3:    return "R6/R10";
            3'd4:    return "R7";
            default: return "R8/R10";
        endcase
    endfunction

    // Behavioural reference built from the requirements.
    function automatic exp_t ref_model(input logic rv, input logic [2:0] m,
                                       input logic [1:0] s, input logic [31:0] b,
                                       input logic [31:0] x, input logic [3:0] d);
        exp_t e;
        logic [31:0] step;
        e = '0;
        e.mode = m;
        e.size = s;
        e.rv = rv;
        step = 32'd1 << s;
        if (!rv) return e;
        if (m > 3'd5 || s == 2'd3) begin
            e.bad = 1'b1;
            return e;
        end
        case (m)
            3'd1: begin e.av = 1'b1; e.ea = b; end
            3'd2: begin e.av = 1'b1; e.ea = b; e.we = 1'b1; e.wv = b + step; end
            3'd3: begin e.av = 1'b1; e.ea = b - step; e.we = 1'b1; e.wv = b - step; end
            3'd4: begin e.av = 1'b1; e.ea = b + {28'd0, d} * step; end
            3'd5: begin e.av = 1'b1; e.ea = b + x; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic check_field(input string tag, input string name,
                               input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
        end
    endtask

    // Driver: present one request on a falling edge and queue its expectation.
    task automatic drive(input logic rv, input logic [2:0] m, input logic [1:0] s,
                         input logic [31:0] b, input logic [31:0] x, input logic [3:0] d);
        @(negedge clk);
        req_valid = rv;
        mode      = m;
        size      = s;
        base_val  = b;
        index_val = x;
        disp      = d;
        sb_q.push_back(ref_model(rv, m, s, b, x, d));
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 2'd0, 32'd0, 32'd0, 4'd0);
    endtask

    // Monitor: compare the response one step after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (monitor_on && sb_q.size() > 0) begin
                exp_t e;
                string t;
                e = sb_q.pop_front();
                t = req_tag(e);
                check_field(t, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e.rv});
                check_field(t, "addr_valid", {31'd0, addr_valid}, {31'd0, e.av});
                check_field(t, "wb_en", {31'd0, wb_en}, {31'd0, e.we});
                check_field(t, "bad_req", {31'd0, bad_req}, {31'd0, e.bad});
                check_field({t, "/R11"}, "eff_addr", eff_addr, e.ea);
                check_field({t, "/R11"}, "wb_value", wb_value, e.wv);
            end
        end
    end

    task automatic check_reset_state();
        check_field("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check_field("R1", "addr_valid", {31'd0, addr_valid}, 32'd0);
        check_field("R1", "wb_en", {31'd0, wb_en}, 32'd0);
        check_field("R1", "bad_req", {31'd0, bad_req}, 32'd0);
        check_field("R1", "eff_addr", eff_addr, 32'd0);
        check_field("R1", "wb_value", wb_value, 32'd0);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] bases [6];
        logic [31:0] idxs  [3];
        logic [3:0]  disps [3];
        bases = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
                  32'h0000_0002, 32'h1234_5670, 32'h8000_0000};
        idxs  = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0010};
        disps = '{4'd0, 4'd15, 4'd6};

        // R1: outputs cleared while reset is held.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        monitor_on = 1'b1;

        // Back-to-back sweep of every mode and size code (R3..R10).
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 4; s++)
                for (int b = 0; b < 6; b++)
                    for (int k = 0; k < 3; k++)
                        drive(1'b1, 3'(m), 2'(s), bases[b], idxs[k], disps[k]);

        // R2: isolated requests separated by idle cycles.
        for (int m = 0; m < 6; m++) begin
            drive(1'b1, 3'(m), 2'd2, 32'h0000_0100, 32'h0000_0004, 4'd15);
            idle();
        end

        // R10: named wrap corners.
        drive(1'b1, 3'd2, 2'd0, 32'hFFFF_FFFF, 32'd0, 4'd0);
        drive(1'b1, 3'd3, 2'd2, 32'h0000_0000, 32'd0, 4'd0);
        drive(1'b1, 3'd4, 2'd2, 32'hFFFF_FFF0, 32'd0, 4'd15);
        drive(1'b1, 3'd5, 2'd1, 32'hFFFF_FFFF, 32'h0000_0002, 4'd0);
        idle();
        idle();
        @(negedge clk);
        monitor_on = 1'b0;

        // R1: reset after traffic clears a live response.
        drive(1'b1, 3'd2, 2'd1, 32'h0000_4000, 32'd0, 4'd0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_reset_state();
        sb_q.delete();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule